// File: doc/BRIEF.md
# Three-Class Weighted Packet Scheduler

This block sits on an in-band packet path toward a control processor. Packets arrive as a stream of words marked with a last-word flag. The first word of each packet carries a small internal header. The block reads a bridge-control flag and a three-bit class-of-service value from that header, assigns the packet to one of three priority classes, and stores it in a ring buffer owned by that class. Because each class has its own ring, a burst in one class can fill only its own storage.

A weighted round-robin arbiter drains the three rings onto a single output stream with a ready/valid handshake. Per-class weights count whole packets. The arbiter changes queue only between packets, so the words of one packet always leave together. A packet that does not fit in its ring is discarded as a whole, and that class's drop counter is incremented.

The ingress controller has three states. `IN_HEAD` waits for a first word. `IN_BODY` stores the later words of an accepted packet. `IN_SKIP` discards the rest of a rejected packet. Its transitions are:
- head→head: a single-word packet is stored or dropped.
- head→body: the first word is stored and the packet goes on.
- head→skip: the first word is rejected and the packet goes on.
- body→head: the last word is stored.
- body→skip: the ring runs out of room part way through the packet.
- skip→head: the last word of a rejected packet arrives.

The arbiter has two states. `ARB_PICK` chooses a queue: it either starts a packet or moves the turn on. `ARB_SEND` streams one packet and returns to `ARB_PICK` once that packet's last word has been accepted.

Top module: `cos_wrr_sched`

## Requirements
- R1: A packet whose first word has bit 3 (the bridge-control flag) set goes to the high class (code 0 on `m_qid`), whatever its class-of-service value.
- R2: When bit 3 is clear, the class-of-service value in bits [2:0] of the first word selects the class. Values 5 to 7 go to high (code 0), values 2 to 4 go to medium (code 1), and values 0 and 1 go to low (code 2).
- R3: No word of a packet appears on the output before the packet's last word has been stored. Each packet leaves with its words unchanged and in order.
- R4: An arriving word finds its ring full when the ring already holds DEPTH words. The whole packet is then dropped, including any of its words already stored, and that class's drop counter increases by one. The other classes' contents and counters are unaffected.
- R5: After reset the first turn belongs to high. A turn serves up to the weight of the current class in packets. The turn then passes in the order high, medium, low, high.
- R6: A class that has no complete packet when its turn is examined loses the rest of its turn. Each such hand-over takes one cycle. While all three classes are empty, the turn position and remaining credit are held.
- R7: A weight of zero is treated as a weight of one.
- R8: The queue choice changes only between packets. While `m_valid` is high and `m_ready` is low, `m_data`, `m_last` and `m_qid` hold steady.
- R9: During and right after reset, `m_valid` is low and all drop counters read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Input word valid; every valid word is taken |
| s_data | input | DATA_W | Input word; the first word of a packet holds the header |
| s_last | input | 1 | Marks the last word of an input packet |
| m_valid | output | 1 | Output word valid |
| m_ready | input | 1 | Downstream accepts the output word |
| m_data | output | DATA_W | Output word |
| m_last | output | 1 | Marks the last word of an output packet |
| m_qid | output | 2 | Class of the packet on the output (0 high, 1 medium, 2 low) |
| weight_hi | input | WT_W | Packets per turn for high |
| weight_med | input | WT_W | Packets per turn for medium |
| weight_low | input | WT_W | Packets per turn for low |
| drop_hi | output | CNT_W | Packets dropped in the high class |
| drop_med | output | CNT_W | Packets dropped in the medium class |
| drop_low | output | CNT_W | Packets dropped in the low class |

## Verification
The assertions assume the input stream is well formed: every packet ends with a word that has `s_last` set. A ring is never pushed and rewound in the same cycle, and that property follows from the ingress controller rather than from the input. The stimulus builds every packet from a length of at least one word and always raises `s_last` on the final word. Words may be separated by idle gaps, and packet lengths are chosen to push rings to exactly full and past full. The weights are changed only while the scheduler is drained, and `m_ready` is varied freely, including long stalls, which the handshake assertions are meant to cover.

// File: rtl/cos_wrr_pkg.sv
package cos_wrr_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int NQ = 3;

    typedef enum logic [1:0] {
        Q_HI  = 2'd0,
        Q_MED = 2'd1,
        Q_LOW = 2'd2
    } qid_t;

    typedef enum logic [1:0] {
        IN_HEAD = 2'd0,
        IN_BODY = 2'd1,
        IN_SKIP = 2'd2
    } in_state_t;

    typedef enum logic {
        ARB_PICK = 1'b0,
        ARB_SEND = 1'b1
    } arb_state_t;

    function automatic qid_t classify(input logic bpdu, input logic [2:0] cos);
        if (bpdu || cos >= 3'd5) return Q_HI;
        if (cos >= 3'd2)         return Q_MED;
        return Q_LOW;
    endfunction

    function automatic qid_t next_q(input qid_t q);
        unique case (q)
            Q_HI:    return Q_MED;
            Q_MED:   return Q_LOW;
            default: return Q_HI;
        endcase
    endfunction
endpackage

// File: rtl/pkt_ring.sv
module pkt_ring #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              push_last,
    input  logic              abort,
    output logic              full,
    input  logic              pop,
    output logic [DATA_W-1:0] head_data,
    output logic              head_last,
    output logic              has_pkt
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic [DATA_W:0] mem [DEPTH];
    logic [PW-1:0]   wr_spec, wr_base, rd_ptr, occ;
    logic [PW-1:0]   pkt_cnt;
    logic            commit, retire;

    assign occ       = wr_spec - rd_ptr;
    assign full      = (occ == PW'(DEPTH));
    assign commit    = push && push_last;
    assign retire    = pop && head_last;
    assign has_pkt   = (pkt_cnt != '0);
    assign head_data = mem[rd_ptr[AW-1:0]][DATA_W-1:0];
    assign head_last = mem[rd_ptr[AW-1:0]][DATA_W];

    always_ff @(posedge clk) begin
        if (push) mem[wr_spec[AW-1:0]] <= {push_last, push_data};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_spec <= '0;
            wr_base <= '0;
            rd_ptr  <= '0;
            pkt_cnt <= '0;
        end else begin
            if (abort) begin
                wr_spec <= wr_base;
            end else if (push) begin
                wr_spec <= wr_spec + PW'(1);
                if (push_last) wr_base <= wr_spec + PW'(1);
            end
            if (pop) rd_ptr <= rd_ptr + PW'(1);
            pkt_cnt <= pkt_cnt + PW'(commit) - PW'(retire);
        end
    end

    // R4
    ring_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    // R3
    pop_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> has_pkt);
    // R4
    push_abort_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && abort));
endmodule

// File: rtl/in_classifier.sv
module in_classifier
    import cos_wrr_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int BPDU_BIT = 3,
    parameter int COS_LSB  = 0,
    parameter int CNT_W    = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      s_valid,
    input  logic [DATA_W-1:0]         s_data,
    input  logic                      s_last,
    input  logic [NQ-1:0]             full,
    output logic [NQ-1:0]             push,
    output logic [NQ-1:0]             abort,
    output logic [NQ-1:0][CNT_W-1:0]  drop_cnt
);
    timeunit 1ns;
    timeprecision 1ps;

    in_state_t st, st_n;
    qid_t      cur_q, hdr_q, tgt;
    logic      drop_hit;

    assign hdr_q = classify(s_data[BPDU_BIT], s_data[COS_LSB +: 3]);
    assign tgt   = (st == IN_HEAD) ? hdr_q : cur_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= IN_HEAD;
            cur_q    <= Q_LOW;
            drop_cnt <= '0;
        end else begin
            st <= st_n;
            if (st == IN_HEAD && s_valid) cur_q <= hdr_q;
            if (drop_hit) drop_cnt[tgt] <= drop_cnt[tgt] + CNT_W'(1);
        end
    end

    always_comb begin
        st_n     = st;
        push     = '0;
        abort    = '0;
        drop_hit = 1'b0;
        unique case (st)
            IN_HEAD: if (s_valid) begin
                if (full[tgt]) begin
                    drop_hit = 1'b1;
                    st_n     = s_last ? IN_HEAD : IN_SKIP;
                end else begin
                    push[tgt] = 1'b1;
                    st_n      = s_last ? IN_HEAD : IN_BODY;
                end
            end
            IN_BODY: if (s_valid) begin
                if (full[tgt]) begin
                    abort[tgt] = 1'b1;
                    drop_hit   = 1'b1;
                    st_n       = s_last ? IN_HEAD : IN_SKIP;
                end else begin
                    push[tgt] = 1'b1;
                    st_n      = s_last ? IN_HEAD : IN_BODY;
                end
            end
            IN_SKIP: if (s_valid && s_last) st_n = IN_HEAD;
            default: st_n = IN_HEAD;
        endcase
    end

    // R1
    bpdu_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == IN_HEAD && s_valid && s_data[BPDU_BIT] && !full[0]) |-> push[0]);
    // R4
    one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(push | abort));
    // R4
    drop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !drop_hit |=> $stable(drop_cnt));
endmodule

// File: rtl/wrr_arbiter.sv
module wrr_arbiter
    import cos_wrr_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int WT_W   = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NQ-1:0]             has_pkt,
    input  logic [NQ-1:0][DATA_W-1:0] head_data,
    input  logic [NQ-1:0]             head_last,
    input  logic [NQ-1:0][WT_W-1:0]   weights,
    output logic [NQ-1:0]             pop,
    output logic                      m_valid,
    input  logic                      m_ready,
    output logic [DATA_W-1:0]         m_data,
    output logic                      m_last,
    output logic [1:0]                m_qid
);
    timeunit 1ns;
    timeprecision 1ps;

    arb_state_t        st, st_n;
    qid_t              cur, cur_n;
    logic [WT_W-1:0]   credit, credit_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ARB_PICK;
            cur    <= Q_LOW;
            credit <= '0;
        end else begin
            st     <= st_n;
            cur    <= cur_n;
            credit <= credit_n;
        end
    end

    always_comb begin
        st_n     = st;
        cur_n    = cur;
        credit_n = credit;
        pop      = '0;
        unique case (st)
            ARB_PICK: if (has_pkt != '0) begin
                if (has_pkt[cur] && credit != '0) begin
                    st_n     = ARB_SEND;
                    credit_n = credit - WT_W'(1);
                end else begin
                    cur_n    = next_q(cur);
                    credit_n = (weights[cur_n] == '0) ? WT_W'(1) : weights[cur_n];
                end
            end
            ARB_SEND: if (m_ready) begin
                pop[cur] = 1'b1;
                if (head_last[cur]) st_n = ARB_PICK;
            end
            default: st_n = ARB_PICK;
        endcase
    end

    always_comb begin
        m_valid = (st == ARB_SEND);
        m_data  = head_data[cur];
        m_last  = head_last[cur];
        m_qid   = cur;
    end

    // R8
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_last) && $stable(m_qid)));
    // R8
    no_interleave_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && m_ready && !m_last) |=> (m_valid && $stable(m_qid)));
    // R3
    send_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(m_valid) |-> $past(has_pkt[cur]));
    // R8
    single_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pop));
endmodule

// File: rtl/cos_wrr_sched.sv
module cos_wrr_sched
    import cos_wrr_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int DEPTH    = 16,
    parameter int WT_W     = 4,
    parameter int CNT_W    = 16,
    parameter int BPDU_BIT = 3,
    parameter int COS_LSB  = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_valid,
    input  logic [DATA_W-1:0] s_data,
    input  logic              s_last,
    output logic              m_valid,
    input  logic              m_ready,
    output logic [DATA_W-1:0] m_data,
    output logic              m_last,
    output logic [1:0]        m_qid,
    input  logic [WT_W-1:0]   weight_hi,
    input  logic [WT_W-1:0]   weight_med,
    input  logic [WT_W-1:0]   weight_low,
    output logic [CNT_W-1:0]  drop_hi,
    output logic [CNT_W-1:0]  drop_med,
    output logic [CNT_W-1:0]  drop_low
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [NQ-1:0]             full, push, abort, pop, has_pkt, head_last;
    logic [NQ-1:0][DATA_W-1:0] head_data;
    logic [NQ-1:0][CNT_W-1:0]  drop_cnt;
    logic [NQ-1:0][WT_W-1:0]   weights;

    assign weights  = {weight_low, weight_med, weight_hi};
    assign drop_hi  = drop_cnt[0];
    assign drop_med = drop_cnt[1];
    assign drop_low = drop_cnt[2];

    in_classifier #(
        .DATA_W(DATA_W), .BPDU_BIT(BPDU_BIT), .COS_LSB(COS_LSB), .CNT_W(CNT_W)
    ) cls_i (
        .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_data(s_data),
        .s_last(s_last), .full(full), .push(push), .abort(abort),
        .drop_cnt(drop_cnt)
    );

    for (genvar q = 0; q < NQ; q++) begin : g_ring
        pkt_ring #(.DATA_W(DATA_W), .DEPTH(DEPTH)) ring_i (
            .clk(clk), .rst_n(rst_n), .push(push[q]), .push_data(s_data),
            .push_last(s_last), .abort(abort[q]), .full(full[q]),
            .pop(pop[q]), .head_data(head_data[q]), .head_last(head_last[q]),
            .has_pkt(has_pkt[q])
        );
    end

    wrr_arbiter #(.DATA_W(DATA_W), .WT_W(WT_W)) arb_i (
        .clk(clk), .rst_n(rst_n), .has_pkt(has_pkt), .head_data(head_data),
        .head_last(head_last), .weights(weights), .pop(pop),
        .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
        .m_last(m_last), .m_qid(m_qid)
    );

    // R9
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!m_valid && drop_hi == '0 && drop_med == '0 && drop_low == '0));
endmodule

// File: tb/cos_wrr_sched_tb.sv
module cos_wrr_sched_tb_top;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        s_valid = 1'b0, s_last = 1'b0, m_ready = 1'b0;
    logic [15:0] s_data = '0;
    logic        m_valid, m_last;
    logic [15:0] m_data;
    logic [1:0]  m_qid;
    logic [3:0]  weight_hi = 4'd4, weight_med = 4'd2, weight_low = 4'd1;
    logic [15:0] drop_hi, drop_med, drop_low;

    always #2.5 clk = ~clk;

    cos_wrr_sched dut_i (
        .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_data(s_data), .s_last(s_last),
        .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_last(m_last),
        .m_qid(m_qid), .weight_hi(weight_hi), .weight_med(weight_med),
        .weight_low(weight_low), .drop_hi(drop_hi), .drop_med(drop_med),
        .drop_low(drop_low)
    );

    // behavioural reference state
    logic [16:0] mq [3][$];
    int specn[3], pk[3], drops[3], wt[3];
    int ist, iq, ast, acur, acred;
    int vecs, fails, seq, rdy_mode, cyc;
    bit done;
    string tag;

    function automatic int cls(input logic b, input logic [2:0] c);
        if (b || c >= 5) return 0;
        if (c >= 2) return 1;
        return 2;
    endfunction

    task automatic chk(input string nm, input int act, input int exp);
        vecs++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h (t=%0t)", tag, nm, act, exp, $time);
        end
    endtask

    task automatic compare();
        chk("m_valid", int'(m_valid), (ast == 1) ? 1 : 0);
        if (ast == 1 && m_valid) begin
            chk("m_qid", int'(m_qid), acur);
            chk("m_data", int'(m_data), int'(mq[acur][0][15:0]));
            chk("m_last", int'(m_last), int'(mq[acur][0][16]));
        end
        chk("drop_hi", int'(drop_hi), drops[0] & 16'hffff);
        chk("drop_med", int'(drop_med), drops[1] & 16'hffff);
        chk("drop_low", int'(drop_low), drops[2] & 16'hffff);
    endtask

    task automatic model_tick(input logic v, input logic [15:0] d, input logic l, input logic r);
        bit full[3];
        int ppk[3];
        int q;
        logic [16:0] w;
        for (int i = 0; i < 3; i++) begin
            full[i] = (mq[i].size() == DEPTH);
            ppk[i]  = pk[i];
        end
        if (ast == 0) begin
            if (ppk[0] + ppk[1] + ppk[2] != 0) begin
                if (ppk[acur] > 0 && acred > 0) begin
                    ast = 1;
                    acred--;
                end else begin
                    acur  = (acur + 1) % 3;
                    acred = (wt[acur] == 0) ? 1 : wt[acur];
                end
            end
        end else if (r) begin
            w = mq[acur].pop_front();
            if (w[16]) begin
                pk[acur]--;
                ast = 0;
            end
        end
        if (v) begin
            case (ist)
                0: begin
                    q = cls(d[3], d[2:0]);
                    if (full[q]) begin
                        drops[q]++;
                        ist = l ? 0 : 2;
                    end else begin
                        mq[q].push_back({l, d});
                        if (l) pk[q]++;
                        else begin specn[q] = 1; ist = 1; iq = q; end
                    end
                end
                1: begin
                    if (full[iq]) begin
                        repeat (specn[iq]) void'(mq[iq].pop_back());
                        specn[iq] = 0;
                        drops[iq]++;
                        ist = l ? 0 : 2;
                    end else begin
                        mq[iq].push_back({l, d});
                        if (l) begin pk[iq]++; specn[iq] = 0; ist = 0; end
                        else specn[iq]++;
                    end
                end
                default: if (l) ist = 0;
            endcase
        end
    endtask

    task automatic step(input logic v, input logic [15:0] d, input logic l);
        logic r;
        @(negedge clk);
        compare();
        r = (rdy_mode == 1) ? 1'b1 : (rdy_mode == 2) ? 1'($urandom_range(0, 1)) : 1'b0;
        s_valid = v; s_data = d; s_last = l; m_ready = r;
        model_tick(v, d, l, r);
    endtask

    task automatic send_pkt(input int cos, input int bpdu, input int len, input int gap);
        for (int i = 0; i < len; i++) begin
            logic [15:0] d;
            d = (i == 0) ? {seq[7:0], 4'h0, 1'(bpdu), 3'(cos)} : {seq[7:0], 8'(i)};
            step(1'b1, d, i == len - 1);
            for (int g = 0; g < gap && i < len - 1; g++) step(1'b0, '0, 1'b0);
        end
        seq++;
    endtask

    task automatic drain();
        rdy_mode = 1;
        for (int k = 0; k < 3000; k++) begin
            if (ast == 0 && pk[0] + pk[1] + pk[2] == 0 && ist == 0) break;
            step(1'b0, '0, 1'b0);
        end
        repeat (2) step(1'b0, '0, 1'b0);
    endtask

    task automatic set_w(input int h, input int m, input int lo);
        weight_hi = 4'(h); weight_med = 4'(m); weight_low = 4'(lo);
        wt[0] = h; wt[1] = m; wt[2] = lo;
    endtask

    task automatic fill(input int nh, input int nm, input int nl, input int len);
        for (int i = 0; i < 8; i++) begin
            if (i < nh) send_pkt(6, 0, len, 0);
            if (i < nm) send_pkt(3, 0, len, 0);
            if (i < nl) send_pkt(0, 0, len, 0);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
            $finish;
        end
    end

    initial begin
        ist = 0; ast = 0; acur = 2; acred = 0;
        for (int i = 0; i < 3; i++) begin specn[i] = 0; pk[i] = 0; drops[i] = 0; end
        set_w(4, 2, 1);
        rdy_mode = 1;
        // R9: quiet outputs while reset is held
        tag = "R9";
        repeat (4) begin
            @(negedge clk);
            compare();
        end
        rst_n = 1'b1;
        repeat (3) step(1'b0, '0, 1'b0);

        // R2: every class-of-service value, flag clear
        tag = "R2";
        for (int c = 0; c < 8; c++) send_pkt(c, 0, 3, 0);
        drain();

        // R1: flag set overrides low and medium values
        tag = "R1";
        send_pkt(0, 1, 2, 0);
        send_pkt(1, 1, 3, 0);
        send_pkt(3, 1, 1, 0);
        drain();

        // R3: sparse words, nothing leaves before the last word
        tag = "R3";
        send_pkt(4, 0, 4, 3);
        send_pkt(7, 0, 5, 2);
        drain();

        // R5: backlog in all classes, weights 4/2/1
        tag = "R5";
        rdy_mode = 0;
        fill(6, 6, 6, 2);
        drain();

        // R7: zero weight on medium
        tag = "R7";
        set_w(2, 0, 3);
        rdy_mode = 0;
        fill(5, 5, 5, 2);
        drain();

        // R6: medium empty, its turn is forfeited
        tag = "R6";
        set_w(3, 3, 3);
        rdy_mode = 0;
        fill(4, 0, 4, 1);
        drain();

        // R4: overflow in low and medium, high unaffected
        tag = "R4";
        set_w(4, 2, 1);
        rdy_mode = 0;
        send_pkt(0, 0, 6, 0);
        send_pkt(0, 0, 6, 0);
        send_pkt(0, 0, 6, 0);
        send_pkt(3, 0, 20, 0);
        send_pkt(6, 0, 2, 0);
        send_pkt(0, 0, 1, 0);
        send_pkt(0, 0, 4, 0);
        send_pkt(1, 0, 1, 0);
        send_pkt(5, 0, 3, 0);
        drain();

        // R8: random stalls with mixed traffic
        tag = "R8";
        rdy_mode = 2;
        for (int n = 0; n < 60; n++)
            send_pkt($urandom_range(0, 7), ($urandom_range(0, 5) == 0) ? 1 : 0,
                     $urandom_range(1, 5), $urandom_range(0, 2));
        rdy_mode = 2;
        repeat (200) step(1'b0, '0, 1'b0);
        drain();

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end
endmodule